// File: doc/BRIEF.md
# Sticky Device Disable Controller

This block holds one disable bit for each on-chip functional block. Each bit that is set drives that block's clock-enable output low, so the block receives no clock at all. The processor core can set bits through one register port and an external bus master through a second port. A write can only add set bits. Once a bit is set, it stays set until the hard system reset clears the whole register, and that reset re-enables every block.

Two bits have a dedicated meaning. One bit stops the core's timer facilities. The other bit holds the core in a stopped state in which it does not take interrupts.

The block also watches accesses to the configuration, control and status registers of the functional blocks. An access that targets a disabled block is a programming error. It produces a one-cycle error pulse and a latched record of which block was targeted. The record stays until software clears it with a read-to-clear strobe.

Top module: `dev_shutoff_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, every disable bit clears. After that edge, `clk_en` is all ones, `timer_stop`, `core_stop` and `err_flag` are 0, and both read-data outputs read 0 after their next read.
- R2: A write on port A with `a_wr_en`=1 ORs `a_wr_data` into the register. From the next clock edge onward, `clk_en[i]` is 0 for every bit i that is set in the data.
- R3: A write on port B with `b_wr_en`=1 ORs `b_wr_data` into the register in the same way as port A.
- R4: When both ports write in the same cycle, the new value is the old value ORed with both data words.
- R5: A write never clears a set bit, including a write of all zeros. Only R1 clears bits.
- R6: `core_stop` equals disable bit CORE_BIT (default 0), and `timer_stop` equals disable bit TIMER_BIT (default 1).
- R7: A read strobe (`a_rd_en` or `b_rd_en`) at a clock edge loads the register value from before that edge's writes into that port's read data. The read data keeps its value while the strobe is low.
- R8: When `acc_valid`=1 and the disable bit of `acc_target` is set at a clock edge, `err_pulse` is 1 for the single cycle after that edge. An access to an enabled block leaves `err_pulse` at 0.
- R9: An error sets `err_flag` and latches `acc_target` into `err_idx`. Later errors leave `err_idx` unchanged while `err_flag` is set. `err_clr` clears `err_flag`. If `err_clr` and an error occur in the same cycle, the flag stays set and `err_idx` takes the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Hard system reset, synchronous, active high |
| a_wr_en | input | 1 | Core port write strobe |
| a_wr_data | input | NUM_BLOCKS | Core port bits to set |
| a_rd_en | input | 1 | Core port read strobe |
| a_rd_data | output | NUM_BLOCKS | Core port read data |
| b_wr_en | input | 1 | External master write strobe |
| b_wr_data | input | NUM_BLOCKS | External master bits to set |
| b_rd_en | input | 1 | External master read strobe |
| b_rd_data | output | NUM_BLOCKS | External master read data |
| clk_en | output | NUM_BLOCKS | Per-block clock enable, low when disabled |
| timer_stop | output | 1 | Core timer facilities stopped |
| core_stop | output | 1 | Core held stopped, ignores interrupts |
| acc_valid | input | 1 | A register access to a block is in progress |
| acc_target | input | IDX_W | Index of the block being accessed |
| err_clr | input | 1 | Read-to-clear strobe for the error status |
| err_pulse | output | 1 | One-cycle access-error pulse |
| err_flag | output | 1 | Error status, held until cleared |
| err_idx | output | IDX_W | Block index of the latched error |

## Verification
The assertions assume that `rst` is high at the first clock edge and that every control input is a defined 0 or 1 at each edge. They also assume that `acc_target` names an existing block whenever `acc_valid` is high. The bench holds reset for the first edges and drives every input to a known value from time zero. It changes inputs only on falling edges and issues accesses only to indices below NUM_BLOCKS. That keeps each monitored property inside these assumptions.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int DSC_DEF_BLOCKS = 32;
  localparam int DSC_DEF_CORE   = 0;
  localparam int DSC_DEF_TIMER  = 1;
endpackage

// File: rtl/dsc_mask_reg.sv
module dsc_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         a_we,
  input  logic [W-1:0] a_wd,
  input  logic         a_re,
  input  logic         b_we,
  input  logic [W-1:0] b_wd,
  input  logic         b_re,
  output logic [W-1:0] mask,
  output logic [W-1:0] a_rd,
  output logic [W-1:0] b_rd
);
  logic [W-1:0] a_set, b_set;
  assign a_set = a_we ? a_wd : '0;
  assign b_set = b_we ? b_wd : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
      a_rd <= '0;
      b_rd <= '0;
    end else begin
      mask <= mask | a_set | b_set;
      if (a_re) a_rd <= mask;
      if (b_re) b_rd <= mask;
    end
  end

  // R5: bits only rise between resets
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (($past(mask) & ~mask) == '0));
  // R2: port A data appears in the register
  a_r2_set: assert property (@(posedge clk) disable iff (rst)
    a_we |=> ((mask & $past(a_wd)) == $past(a_wd)));
  // R3: port B data appears in the register
  a_r3_set: assert property (@(posedge clk) disable iff (rst)
    b_we |=> ((mask & $past(b_wd)) == $past(b_wd)));
endmodule

// File: rtl/dsc_access_chk.sv
module dsc_access_chk #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     mask,
  input  logic             acc_valid,
  input  logic [IDX_W-1:0] acc_target,
  input  logic             err_clr,
  output logic             err_pulse,
  output logic             err_flag,
  output logic [IDX_W-1:0] err_idx
);
  logic in_range, hit;
  assign in_range = (int'(acc_target) < N);
  assign hit      = acc_valid && in_range && mask[acc_target];

  always_ff @(posedge clk) begin
    if (rst) begin
      err_pulse <= 1'b0;
      err_flag  <= 1'b0;
      err_idx   <= '0;
    end else begin
      err_pulse <= hit;
      if (hit && (!err_flag || err_clr)) begin
        err_flag <= 1'b1;
        err_idx  <= acc_target;
      end else if (err_clr) begin
        err_flag <= 1'b0;
      end
    end
  end

  // R8: no access, no pulse in the following cycle
  a_r8_quiet: assert property (@(posedge clk) disable iff (rst)
    !acc_valid |=> !err_pulse);
  // R9: a pulse leaves the status flag set
  a_r9_flag: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> err_flag);
  // R9: latched index holds while not cleared
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !err_clr) |=> (err_flag && $stable(err_idx)));
endmodule

// File: rtl/dev_shutoff_ctrl.sv
module dev_shutoff_ctrl #(
  parameter int NUM_BLOCKS = dsc_pkg::DSC_DEF_BLOCKS,
  parameter int CORE_BIT   = dsc_pkg::DSC_DEF_CORE,
  parameter int TIMER_BIT  = dsc_pkg::DSC_DEF_TIMER,
  localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  a_wr_en,
  input  logic [NUM_BLOCKS-1:0] a_wr_data,
  input  logic                  a_rd_en,
  output logic [NUM_BLOCKS-1:0] a_rd_data,
  input  logic                  b_wr_en,
  input  logic [NUM_BLOCKS-1:0] b_wr_data,
  input  logic                  b_rd_en,
  output logic [NUM_BLOCKS-1:0] b_rd_data,
  output logic [NUM_BLOCKS-1:0] clk_en,
  output logic                  timer_stop,
  output logic                  core_stop,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_target,
  input  logic                  err_clr,
  output logic                  err_pulse,
  output logic                  err_flag,
  output logic [IDX_W-1:0]      err_idx
);
  logic [NUM_BLOCKS-1:0] mask;

  dsc_mask_reg #(.W(NUM_BLOCKS)) u_reg (
    .clk(clk), .rst(rst),
    .a_we(a_wr_en), .a_wd(a_wr_data), .a_re(a_rd_en),
    .b_we(b_wr_en), .b_wd(b_wr_data), .b_re(b_rd_en),
    .mask(mask), .a_rd(a_rd_data), .b_rd(b_rd_data)
  );

  dsc_access_chk #(.N(NUM_BLOCKS), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .mask(mask),
    .acc_valid(acc_valid), .acc_target(acc_target), .err_clr(err_clr),
    .err_pulse(err_pulse), .err_flag(err_flag), .err_idx(err_idx)
  );

  assign clk_en     = ~mask;
  assign timer_stop = mask[TIMER_BIT];
  assign core_stop  = mask[CORE_BIT];

  // R1: reset re-enables every block
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (clk_en == '1 && !err_flag));
  // R8: access to a gated block gives an error pulse next cycle
  a_r8_pulse: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !clk_en[acc_target]) |=> err_pulse);
endmodule

// File: tb/sim_dev_shutoff_ctrl.sv
module sim_dev_shutoff_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic clk = 0, rst = 1;
  logic a_wr_en = 0, a_rd_en = 0, b_wr_en = 0, b_rd_en = 0;
  logic [N-1:0] a_wr_data = '0, b_wr_data = '0;
  logic [N-1:0] a_rd_data, b_rd_data, clk_en;
  logic timer_stop, core_stop, acc_valid = 0, err_clr = 0;
  logic err_pulse, err_flag;
  logic [4:0] acc_target = '0, err_idx;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dev_shutoff_ctrl u0 (
    .clk(clk), .rst(rst),
    .a_wr_en(a_wr_en), .a_wr_data(a_wr_data), .a_rd_en(a_rd_en), .a_rd_data(a_rd_data),
    .b_wr_en(b_wr_en), .b_wr_data(b_wr_data), .b_rd_en(b_rd_en), .b_rd_data(b_rd_data),
    .clk_en(clk_en), .timer_stop(timer_stop), .core_stop(core_stop),
    .acc_valid(acc_valid), .acc_target(acc_target), .err_clr(err_clr),
    .err_pulse(err_pulse), .err_flag(err_flag), .err_idx(err_idx)
  );

  // {a_we, a_data, b_we, b_data, expected mask}
  localparam logic [97:0] VEC [6] = '{
    {1'b1, 32'h0000_0010, 1'b0, 32'h0,          32'h0000_0010},
    {1'b0, 32'h0,          1'b1, 32'h0000_0300, 32'h0000_0310},
    {1'b1, 32'h0,          1'b1, 32'h0,          32'h0000_0310},
    {1'b1, 32'h0001_0000, 1'b1, 32'h8000_0000, 32'h8001_0310},
    {1'b1, 32'h0000_0010, 1'b0, 32'h0,          32'h8001_0310},
    {1'b0, 32'h0,          1'b1, 32'h0000_0002, 32'h8001_0312}
  };
  localparam string VTAG [6] = '{"R2", "R3", "R5", "R4", "R5", "R3"};

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    a_wr_en = 0; b_wr_en = 0; a_rd_en = 0; b_rd_en = 0;
    acc_valid = 0; err_clr = 0;
  endtask

  task automatic access(logic [4:0] t, logic clr);
    @(negedge clk); acc_valid = 1; acc_target = t; err_clr = clr;
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    chk("R1 clk_en", clk_en, 32'hFFFF_FFFF);
    chk("R1 stops", {30'b0, timer_stop, core_stop}, 32'h0);
    chk("R1 err_flag", {31'b0, err_flag}, 32'h0);

    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      a_wr_en = VEC[i][97]; a_wr_data = VEC[i][96:65];
      b_wr_en = VEC[i][64]; b_wr_data = VEC[i][63:32];
      @(negedge clk); idle();
      chk({VTAG[i], " clk_en"}, clk_en, ~VEC[i][31:0]);
    end

    // R6: dedicated bits
    chk("R6 timer_stop", {31'b0, timer_stop}, 32'h1);
    chk("R6 core_stop low", {31'b0, core_stop}, 32'h0);

    // R7: read returns pre-write value, then holds
    @(negedge clk); a_rd_en = 1; b_rd_en = 1; a_wr_en = 1; a_wr_data = 32'h0000_0001;
    @(negedge clk); idle();
    chk("R7 a_rd pre-write", a_rd_data, 32'h8001_0312);
    chk("R7 b_rd pre-write", b_rd_data, 32'h8001_0312);
    chk("R6 core_stop", {31'b0, core_stop}, 32'h1);
    @(negedge clk); @(negedge clk);
    chk("R7 a_rd hold", a_rd_data, 32'h8001_0312);
    @(negedge clk); b_rd_en = 1;
    @(negedge clk); idle();
    chk("R7 b_rd new", b_rd_data, 32'h8001_0313);

    // R8: access to disabled block 4
    @(negedge clk); acc_valid = 1; acc_target = 5'd4;
    @(negedge clk); idle();
    chk("R8 pulse", {31'b0, err_pulse}, 32'h1);
    chk("R9 flag", {31'b0, err_flag}, 32'h1);
    chk("R9 idx", {27'b0, err_idx}, 32'd4);
    @(negedge clk);
    chk("R8 single cycle", {31'b0, err_pulse}, 32'h0);
    // R8: enabled block 5 gives no pulse
    @(negedge clk); acc_valid = 1; acc_target = 5'd5;
    @(negedge clk); idle();
    chk("R8 enabled no pulse", {31'b0, err_pulse}, 32'h0);
    // R9: second error keeps first index
    access(5'd8, 1'b0);
    chk("R9 idx kept", {27'b0, err_idx}, 32'd4);
    // R9: clear
    @(negedge clk); err_clr = 1;
    @(negedge clk); idle();
    chk("R9 cleared", {31'b0, err_flag}, 32'h0);
    // R9: clear with new error
    access(5'd9, 1'b1);
    chk("R9 clr+err flag", {31'b0, err_flag}, 32'h1);
    chk("R9 clr+err idx", {27'b0, err_idx}, 32'd9);

    // R1/R5: hard reset is the only way to clear
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; a_rd_en = 1;
    @(negedge clk); idle();
    chk("R1 re-reset clk_en", clk_en, 32'hFFFF_FFFF);
    chk("R1 re-reset rd", a_rd_data, 32'h0);
    chk("R1 re-reset flag", {31'b0, err_flag}, 32'h0);
    access(5'd4, 1'b0);
    chk("R8 no error after reset", {31'b0, err_flag}, 32'h0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1..all act=hung exp=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule